// File: doc/BRIEF.md
# Upper Memory Bank Switch Controller

This block steers every CPU access to the upper 12K of a 16-bit address space ($D000–$FFFF). That space can be served by ROM or by RAM. The RAM side has two 4K banks for the $D000–$DFFF window and one shared 8K area for $E000–$FFFF. Reads and writes are steered independently, so software can read ROM while writing into RAM underneath it, and can shadow ROM into RAM that way.

A small control state is held in a register. Any access, read or write, to the sixteen switch locations at $C080–$C08F loads that state from the low address bits. Bit 2 is discarded, and bits 0, 1 and 3 are kept. The low two bits pick one of four read/write modes, and bit 3 picks the bank.

For each access to the upper region, the block drives these outputs:
- a ROM/RAM read select;
- a RAM write enable;
- a main/auxiliary select, taken from the external alternate zero-page flag;
- the 16-bit physical RAM offset.

Bank 1 of the $D000 window is stored in RAM at the $C000 offset. Two status reads report the selected bank and whether ROM is being read. The memory arrays are outside the block.

Top module: `lcBankCtrl`

## Requirements
- R1: After reset the state is 4'b0010: upper reads select ROM, upper writes are not enabled, and bank 2 is selected.
- R2: Any valid access, read or write, with address in $C080–$C08F loads the state with address[3:0] AND 4'b1011 at the next clock edge. Address bit 2 has no effect on the result.
- R3: For an upper access, readRom is 1 exactly when state bit 0 differs from state bit 1. The mode encodings are: 00 reads RAM without writing, 01 reads ROM and writes RAM, 10 reads ROM without writing, and 11 reads and writes RAM.
- R4: In the $D000–$DFFF window, ramOffset equals the address when state bit 3 is 0 (bank 2). It equals the address minus $1000 (the $C000–$CFFF offset) when state bit 3 is 1 (bank 1).
- R5: In the $E000–$FFFF window, ramOffset equals the address in every state.
- R6: During an upper access, auxSel equals the altZp input.
- R7: ramWrEn is 1 only for a valid write to $D000–$FFFF while state bit 0 is 1. Writes in the modes with no write leave it at 0.
- R8: A valid read of $C011 sets statValid, with statData = $80 when the state value is below 4 and $00 otherwise.
- R9: A valid read of $C012 sets statValid, with statData = $00 when state bit 0 XOR bit 1 is 1 and $80 otherwise.
- R10: For an access outside $D000–$FFFF, or with accValid low, the following are all 0: upHit, readRom, ramWrEn, auxSel and ramOffset.
- R11: Writes to $C011/$C012 give statValid = 0. Status reads and other non-switch accesses leave the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | An access is present this cycle |
| accWrite | input | 1 | 1 = write access, 0 = read access |
| accAddr | input | 16 | Access address |
| altZp | input | 1 | Alternate zero-page flag; selects auxiliary RAM |
| upHit | output | 1 | Access falls in $D000–$FFFF |
| readRom | output | 1 | Upper read is served by ROM (0 = RAM) |
| ramWrEn | output | 1 | Upper write goes into RAM |
| auxSel | output | 1 | Upper RAM access uses the auxiliary bank |
| ramOffset | output | 16 | Physical RAM offset for an upper access |
| statValid | output | 1 | A status read is being answered |
| statData | output | 8 | Status byte, flag in bit 7 |

## Verification
The assertions check these properties on every cycle:
- a write enable never appears without a write to the upper window;
- outputs are quiet outside that window;
- $E000 offsets pass straight through;
- $D000 offsets land in $C000 or $D000;
- auxSel follows altZp;
- status bytes carry only bit 7;
- the read source is steady across cycles that contain no switch access.

Only the bench's scenarios can show two things. The first is that each of the sixteen switch addresses produces the correct mode and bank, including bit 2 being dropped. The second is that status bytes and offsets match the state loaded by earlier accesses.

// File: rtl/lcBankPkg.sv
package lcBankPkg;

  // Decoded access classes passed from control to datapath.
  typedef struct packed {
    logic switchHit;  // access to the switch locations: load state
    logic upperHit;   // access falls in the upper region
    logic lowWin;     // upper access is in the banked 4K window
    logic upWrite;    // upper access is a write
    logic bankStat;   // read of the bank status location
    logic romStat;    // read of the ROM status location
  } lcStrobe_t;

  localparam int STATE_W = 4;

endpackage

// File: rtl/lcBankCtl.sv
module lcBankCtl
  import lcBankPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SWITCH_BASE = 16'hC080,
  parameter logic [ADDR_W-1:0] UPPER_BASE  = 16'hD000,
  parameter logic [ADDR_W-1:0] SHARED_BASE = 16'hE000,
  parameter logic [ADDR_W-1:0] BANK_STAT   = 16'hC011,
  parameter logic [ADDR_W-1:0] ROM_STAT    = 16'hC012
) (
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  output lcStrobe_t         strobes
);

  localparam int SEL_LSB = 4;

  logic inSwitch;
  logic inUpper;
  logic isRead;

  always_comb begin
    inSwitch = accAddr[ADDR_W-1:SEL_LSB] == SWITCH_BASE[ADDR_W-1:SEL_LSB];
    inUpper  = accAddr >= UPPER_BASE;
    isRead   = accValid && !accWrite;

    strobes.switchHit = accValid && inSwitch;
    strobes.upperHit  = accValid && inUpper;
    strobes.lowWin    = accValid && inUpper && (accAddr < SHARED_BASE);
    strobes.upWrite   = accValid && inUpper && accWrite;
    strobes.bankStat  = isRead && (accAddr == BANK_STAT);
    strobes.romStat   = isRead && (accAddr == ROM_STAT);
  end

endmodule

// File: rtl/lcBankDp.sv
module lcBankDp
  import lcBankPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [STATE_W-1:0] RESET_STATE = 4'b0010,
  parameter logic [STATE_W-1:0] KEEP_MASK   = 4'b1011,
  parameter logic [ADDR_W-1:0]  BANK1_CLEAR = 16'h1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  lcStrobe_t         strobes,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              altZp,
  output logic              upHit,
  output logic              readRom,
  output logic              ramWrEn,
  output logic              auxSel,
  output logic [ADDR_W-1:0] ramOffset,
  output logic              statValid,
  output logic [DATA_W-1:0] statData
);

  localparam int FLAG_LOW_W = DATA_W - 1;

  logic [STATE_W-1:0] modeQ;
  logic               romRead;
  logic               wrAllowed;
  logic               bank1Sel;
  logic               stateLow;
  logic               flagBit;

  // Control state register, loaded from the switch address.
  always_ff @(posedge clk) begin
    if (!rstN)
      modeQ <= RESET_STATE;
    else if (strobes.switchHit)
      modeQ <= accAddr[STATE_W-1:0] & KEEP_MASK;
  end

  always_comb begin
    romRead   = modeQ[0] ^ modeQ[1];
    wrAllowed = modeQ[0];
    bank1Sel  = modeQ[3];
    stateLow  = modeQ < STATE_W'(4);
  end

  // Upper-region steering.
  always_comb begin
    upHit     = strobes.upperHit;
    readRom   = strobes.upperHit && romRead;
    ramWrEn   = strobes.upWrite && wrAllowed;
    auxSel    = strobes.upperHit && altZp;
    ramOffset = '0;
    if (strobes.upperHit) begin
      if (strobes.lowWin && bank1Sel)
        ramOffset = accAddr & ~BANK1_CLEAR;
      else
        ramOffset = accAddr;
    end
  end

  // Status byte: flag in the top bit, zeros below.
  always_comb begin
    statValid = strobes.bankStat || strobes.romStat;
    flagBit   = 1'b0;
    if (strobes.bankStat)
      flagBit = stateLow;
    else if (strobes.romStat)
      flagBit = !romRead;
  end

  generate
    if (FLAG_LOW_W > 0) begin : g_wideStat
      assign statData = {flagBit, {FLAG_LOW_W{1'b0}}};
    end else begin : g_bitStat
      assign statData = flagBit;
    end
  endgenerate

endmodule

// File: rtl/lcBankCtrl.sv
module lcBankCtrl
  import lcBankPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              altZp,
  output logic              upHit,
  output logic              readRom,
  output logic              ramWrEn,
  output logic              auxSel,
  output logic [ADDR_W-1:0] ramOffset,
  output logic              statValid,
  output logic [DATA_W-1:0] statData
);

  lcStrobe_t strobes;

  lcBankCtl #(.ADDR_W(ADDR_W)) i_ctl (
    .accValid (accValid),
    .accWrite (accWrite),
    .accAddr  (accAddr),
    .strobes  (strobes)
  );

  lcBankDp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .accAddr   (accAddr),
    .altZp     (altZp),
    .upHit     (upHit),
    .readRom   (readRom),
    .ramWrEn   (ramWrEn),
    .auxSel    (auxSel),
    .ramOffset (ramOffset),
    .statValid (statValid),
    .statData  (statData)
  );

endmodule

// File: rtl/lcBankChk.sv
module lcBankChk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              accValid,
  input logic              accWrite,
  input logic [ADDR_W-1:0] accAddr,
  input logic              altZp,
  input logic              upHit,
  input logic              readRom,
  input logic              ramWrEn,
  input logic              auxSel,
  input logic [ADDR_W-1:0] ramOffset,
  input logic              statValid,
  input logic [DATA_W-1:0] statData
);

  logic switchAcc;
  assign switchAcc = accValid && (accAddr[ADDR_W-1:4] == 12'hC08);

  // R7: a RAM write only ever accompanies a write into the upper region
  p_wr_only_on_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    ramWrEn |-> (accValid && accWrite && upHit));

  // R10: quiet outside the upper region
  p_quiet_outside_r10: assert property (@(posedge clk) disable iff (!rstN)
    !upHit |-> (!readRom && !ramWrEn && !auxSel && ramOffset == '0));

  // R5: shared window offsets pass straight through
  p_shared_offset_r5: assert property (@(posedge clk) disable iff (!rstN)
    (upHit && accAddr[15:13] == 3'b111) |-> (ramOffset == accAddr));

  // R4: banked window lands at the $C000 or $D000 offset
  p_bank_offset_r4: assert property (@(posedge clk) disable iff (!rstN)
    (upHit && accAddr[15:12] == 4'hD) |->
      (ramOffset[15:13] == 3'b110 && ramOffset[11:0] == accAddr[11:0]));

  // R6: auxiliary select follows the flag
  p_aux_follows_r6: assert property (@(posedge clk) disable iff (!rstN)
    upHit |-> (auxSel == altZp));

  // R8: status byte carries only its top bit
  p_stat_clean_r8: assert property (@(posedge clk) disable iff (!rstN)
    statValid |-> (statData[DATA_W-2:0] == '0));

  // R11: status is answered only for reads
  p_stat_read_only_r11: assert property (@(posedge clk) disable iff (!rstN)
    statValid |-> !accWrite);

  // R11: read source steady when no switch access happened in between
  p_state_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (upHit && $past(upHit) && !$past(switchAcc) && $past(rstN)) |->
      (readRom == $past(readRom)));

endmodule

bind lcBankCtrl lcBankChk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .accValid  (accValid),
  .accWrite  (accWrite),
  .accAddr   (accAddr),
  .altZp     (altZp),
  .upHit     (upHit),
  .readRom   (readRom),
  .ramWrEn   (ramWrEn),
  .auxSel    (auxSel),
  .ramOffset (ramOffset),
  .statValid (statValid),
  .statData  (statData)
);

// File: tb/test_lcBankCtrl.sv
module test_lcBankCtrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0;
  logic        accWrite = 1'b0;
  logic [15:0] accAddr = '0;
  logic        altZp = 1'b0;
  logic        upHit, readRom, ramWrEn, auxSel, statValid;
  logic [15:0] ramOffset;
  logic [7:0]  statData;

  int testsRun = 0;
  int testsFailed = 0;
  int refState = 2;
  bit finished = 0;

  always #10 clk = ~clk;

  lcBankCtrl i_lcBankCtrl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accAddr(accAddr), .altZp(altZp), .upHit(upHit), .readRom(readRom),
    .ramWrEn(ramWrEn), .auxSel(auxSel), .ramOffset(ramOffset),
    .statValid(statValid), .statData(statData)
  );

  task automatic check(string tag, string what, int act, int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // One access: drive at negedge, compare mid-low-phase, update model at posedge.
  task automatic doAcc(string tag, bit v, bit w, int a, bit az);
    bit up, isStat;
    int expOff, expStat;
    @(negedge clk);
    accValid = v; accWrite = w; accAddr = 16'(a); altZp = az;
    #5;
    up = v && (a >= 'hD000);
    expOff = 0;
    if (up) expOff = (a < 'hE000 && refState[3]) ? a - 'h1000 : a;
    isStat = v && !w && (a == 'hC011 || a == 'hC012);
    expStat = 0;
    if (isStat && a == 'hC011) expStat = (refState < 4) ? 'h80 : 0;
    if (isStat && a == 'hC012) expStat = (refState[0] ^ refState[1]) ? 0 : 'h80;
    check(tag, "upHit", int'(upHit), int'(up));
    check(tag, "readRom", int'(readRom), int'(up && (refState[0] ^ refState[1])));
    check(tag, "ramWrEn", int'(ramWrEn), int'(up && w && refState[0]));
    check(tag, "auxSel", int'(auxSel), int'(up && az));
    check(tag, "ramOffset", int'(ramOffset), expOff);
    check(tag, "statValid", int'(statValid), int'(isStat));
    check(tag, "statData", int'(statData), expStat);
    @(posedge clk);
    if (v && (a >= 'hC080) && (a <= 'hC08F)) refState = a & 'hB;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state reads ROM, no write, bank 2
    doAcc("R1", 1, 0, 'hD123, 0);
    doAcc("R1", 1, 1, 'hD123, 0);
    doAcc("R1", 1, 0, 'hC011, 0);
    doAcc("R1", 1, 0, 'hC012, 0);
    // Walk all sixteen switch addresses, alternating read and write triggers
    for (int s = 0; s < 16; s++) begin
      doAcc("R2", 1, s[0], 'hC080 + s, 0);
      doAcc("R3", 1, 0, 'hD800, 0);
      doAcc("R7", 1, 1, 'hD800, 0);
      doAcc("R4", 1, 1, 'hDFFF, s[1]);
      doAcc("R5", 1, 1, 'hE100, 0);
      doAcc("R5", 1, 0, 'hFFFF, 1);
      doAcc("R6", 1, 1, 'hE000, 1);
      doAcc("R8", 1, 0, 'hC011, 0);
      doAcc("R9", 1, 0, 'hC012, 0);
    end
    // R10: outside the region and idle cycles
    doAcc("R10", 1, 1, 'h1234, 1);
    doAcc("R10", 1, 0, 'hCFFF, 1);
    doAcc("R10", 0, 1, 'hD000, 1);
    doAcc("R10", 0, 0, 'hC08B, 0);  // invalid switch access must not load
    doAcc("R10", 1, 0, 'hD000, 0);
    // R11: status writes and status reads leave state alone
    doAcc("R2", 1, 1, 'hC08B, 0);
    doAcc("R11", 1, 1, 'hC011, 0);
    doAcc("R11", 1, 1, 'hC012, 0);
    doAcc("R11", 1, 0, 'hC011, 0);
    doAcc("R11", 1, 1, 'hD400, 0);
    doAcc("R11", 1, 0, 'hC012, 0);
    // R2: bit 2 dropped, back-to-back switches
    doAcc("R2", 1, 0, 'hC086, 0);
    doAcc("R2", 1, 1, 'hC085, 0);
    doAcc("R4", 1, 1, 'hD000, 0);
    doAcc("R8", 1, 0, 'hC011, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule